// File: doc/BRIEF.md
# Boundary-Scan Register Segment

This block is one stretch of a boundary-scan register that sits between the core and the pads. It holds an ordered chain of cells of four kinds: observe-only cells on input pins, plain output cells, tri-state data cells, and control cells. Each control cell gates the output enable of exactly one tri-state data cell. A test access port controller outside the block supplies the serial input and the capture, shift and update strobes. The serial output of the segment feeds the next segment or the test data output.

Each cell has a shift stage. Every cell except an observe-only cell also has an update latch behind its shift stage. Capture loads the shift stages from the pin side or the core side. Shift moves the chain one place toward the serial output each clock. Update copies the shift stages into the latches. While test mode is low the core drives the pads directly and the chain is invisible to them. While it is high the pads take their data and enables from the update latches. So a sample pass never disturbs the pads. A preload pass followed by raising test mode puts known values on them at once.

The chain order is fixed by three parameters: `N_OBS`, `N_OUT` and `N_TRI`, each at least 1. Let `B = N_OBS + N_OUT`. Cells `0 .. N_OBS-1` are observe-only, and cell 0 is next to the serial output. Cells `N_OBS .. B-1` are plain outputs. Cells `B+2k` and `B+2k+1` are the data cell and the control cell of tri-state pin `k`. The highest-numbered cell is next to the serial input.

Top module: `bsr_segment`

## Requirements
- R1: Reset (`rst_n` low) clears every shift stage and every update latch to 0. After reset, `tdo` is 0. In test mode every `pin_out` and `pin_tri_d` bit is 0 and every `pin_tri_oe` bit is 0, so each tri-state pin is disabled.
- R2: While `test_mode` is 0, `pin_out`, `pin_tri_d` and `pin_tri_oe` equal `core_out`, `core_tri_d` and `core_tri_oe` in the same cycle, whatever the strobes do.
- R3: A clock edge with `capture_en` high loads the shift stages as follows. Cell `i < N_OBS` takes `pin_in[i]`. Cell `N_OBS+j` takes `core_out[j]`. Cell `B+2k` takes `core_tri_d[k]`. Cell `B+2k+1` takes `core_tri_oe[k]`.
- R4: A clock edge with `shift_en` high and `capture_en` low moves each cell `i` to cell `i-1` and loads `tdi` into the highest cell. `tdo` always shows shift stage 0.
- R5: In test mode the pins change only on the edge after a cycle with `update_en` high. Capturing and shifting leave them unchanged.
- R6: In test mode, `pin_out[j]` is the latch of cell `N_OBS+j`. `pin_tri_d[k]` and `pin_tri_oe[k]` are the latches of cells `B+2k` and `B+2k+1`. The core inputs have no effect on the pins.
- R7: When the control latch of tri-state pin `k` holds 0, `pin_tri_oe[k]` is 0 in test mode, even when its data latch holds 1.
- R8: Observe-only cells have no update latch. The bits held in cells `0 .. N_OBS-1` at update time change no pin.
- R9: When `capture_en` and `shift_en` are both high on the same edge, the capture happens and the shift is dropped.
- R10: An update with `test_mode` low leaves the pins on the core (preload). Raising `test_mode` afterwards shows the preloaded values on the pins in that same cycle, without waiting for a clock.
- R11: A clock edge with neither `capture_en` nor `shift_en` high leaves all shift stages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 1: pins driven from the update latches; 0: pins driven by the core |
| capture_en | input | 1 | Capture strobe from the TAP |
| shift_en | input | 1 | Shift strobe from the TAP |
| update_en | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data into the highest cell |
| tdo | output | 1 | Serial data out of cell 0 |
| pin_in | input | N_OBS | Input pin levels seen by the observe-only cells |
| core_out | input | N_OUT | Core data for the plain output pins |
| core_tri_d | input | N_TRI | Core data for the tri-state pins |
| core_tri_oe | input | N_TRI | Core output enables for the tri-state pins |
| pin_out | output | N_OUT | Data to the plain output pads |
| pin_tri_d | output | N_TRI | Data to the tri-state pads |
| pin_tri_oe | output | N_TRI | Enables to the tri-state pads; 0 means high-impedance |

## Verification
The bench runs several capture patterns with mixed, inverted and alternating values on the pin inputs and the core inputs. It shifts each result out through `tdo` while loading a new pattern, so a swapped cell position or a wrong capture source shows up as a bit error at a known place in the stream. A second pass with no capture reads back exactly what was shifted in, which checks the shift path apart from capture. Update patterns then separate a preload from a live update. One pattern sets a data bit to 1 under a control bit of 0, to confirm the disable. Another differs from the current one only in the observe-only bits, to show that those bits reach no pin. A pass with capture and shift on the same edge, and a capture followed by idle cycles, cover the strobe priority and the hold behaviour.

// File: rtl/bsr_pkg.sv
// Package: cell kinds of the boundary-scan segment and the mapping from a
// chain position to its kind and to its slot within that kind's group.
// Assumes the fixed layout: observe cells, then plain outputs, then
// tri-state data/control pairs, counted upward from the serial output.
package bsr_pkg;

    typedef enum logic [1:0] {
        CK_OBSERVE,
        CK_OUTPUT,
        CK_TRI_DATA,
        CK_TRI_CTRL
    } cell_kind_e;

    // Kind of the cell at chain position idx.
    function automatic cell_kind_e kind_of(input int idx, input int n_obs, input int n_out);
        if (idx < n_obs)                      return CK_OBSERVE;
        else if (idx < n_obs + n_out)         return CK_OUTPUT;
        else if (((idx - n_obs - n_out) % 2) == 0) return CK_TRI_DATA;
        else                                  return CK_TRI_CTRL;
    endfunction

    // Index of the pin or core signal that belongs to chain position idx.
    function automatic int slot_of(input int idx, input int n_obs, input int n_out);
        if (idx < n_obs)              return idx;
        else if (idx < n_obs + n_out) return idx - n_obs;
        else                          return (idx - n_obs - n_out) / 2;
    endfunction

endpackage

// File: rtl/bsr_capture_chain.sv
// Shift stages of the segment. Loads the parallel capture vector on
// capture, otherwise shifts toward position 0 on shift, otherwise holds.
// Assumes LEN >= 2. Capture takes priority over shift.
module bsr_capture_chain #(
    parameter int LEN = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture_en,
    input  logic           shift_en,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] stage,
    output logic           tdo
);

    // Capture, shift or hold the stage vector each test clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (capture_en) begin
            stage <= cap_vec;
        end else if (shift_en) begin
            stage <= {tdi, stage[LEN-1:1]};
        end
    end

    // Serial output is the cell nearest the segment end.
    assign tdo = stage[0];

endmodule

// File: rtl/bsr_update_bank.sv
// Update latches for the cells that can drive a pin. Copies the matching
// shift stages when the update strobe is high. Reset gives 0, which is the
// disable value of every control cell.
module bsr_update_bank #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             update_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Take a parallel copy of the shift stages on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (update_en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bsr_pin_select.sv
// Pin-side multiplexer. In test mode the pins come from the update latches,
// otherwise from the core. Latch layout: plain outputs in the low N_OUT
// bits, then a data/control pair for each tri-state pin.
module bsr_pin_select #(
    parameter int N_OUT = 3,
    parameter int N_TRI = 2,
    localparam int WIDTH = N_OUT + 2 * N_TRI
) (
    input  logic             test_mode,
    input  logic [WIDTH-1:0] hold,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_TRI-1:0] core_tri_d,
    input  logic [N_TRI-1:0] core_tri_oe,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_TRI-1:0] pin_tri_d,
    output logic [N_TRI-1:0] pin_tri_oe
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        // Plain output: the latch or the core drives the pad.
        assign pin_out[j] = test_mode ? hold[j] : core_out[j];
    end

    for (genvar k = 0; k < N_TRI; k++) begin : g_tri
        // Tri-state pin: the data latch and its own control latch.
        assign pin_tri_d[k]  = test_mode ? hold[N_OUT + 2*k]     : core_tri_d[k];
        assign pin_tri_oe[k] = test_mode ? hold[N_OUT + 2*k + 1] : core_tri_oe[k];
    end

endmodule

// File: rtl/bsr_segment.sv
// Top of the boundary-scan register segment. Builds the capture vector from
// the cell layout in bsr_pkg, then connects the shift chain, the update bank
// (no latch for observe-only cells) and the pin multiplexer.
// Assumes N_OBS, N_OUT and N_TRI are each at least 1.
module bsr_segment #(
    parameter int N_OBS = 2,
    parameter int N_OUT = 3,
    parameter int N_TRI = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             tdi,
    output logic             tdo,
    input  logic [N_OBS-1:0] pin_in,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_TRI-1:0] core_tri_d,
    input  logic [N_TRI-1:0] core_tri_oe,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_TRI-1:0] pin_tri_d,
    output logic [N_TRI-1:0] pin_tri_oe
);

    import bsr_pkg::*;

    localparam int LEN = N_OBS + N_OUT + 2 * N_TRI;
    localparam int UPD = LEN - N_OBS;

    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] stage;
    logic [UPD-1:0] hold;

    for (genvar i = 0; i < LEN; i++) begin : g_cap
        localparam cell_kind_e KIND = kind_of(i, N_OBS, N_OUT);
        localparam int         SLOT = slot_of(i, N_OBS, N_OUT);
        // Select the capture source of cell i by its kind.
        if (KIND == CK_OBSERVE) begin : g_obs
            assign cap_vec[i] = pin_in[SLOT];
        end else if (KIND == CK_OUTPUT) begin : g_o2
            assign cap_vec[i] = core_out[SLOT];
        end else if (KIND == CK_TRI_DATA) begin : g_o3
            assign cap_vec[i] = core_tri_d[SLOT];
        end else begin : g_ctl
            assign cap_vec[i] = core_tri_oe[SLOT];
        end
    end

    bsr_capture_chain #(.LEN(LEN)) chain_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .tdi        (tdi),
        .cap_vec    (cap_vec),
        .stage      (stage),
        .tdo        (tdo)
    );

    bsr_update_bank #(.WIDTH(UPD)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .update_en (update_en),
        .d         (stage[LEN-1:N_OBS]),
        .q         (hold)
    );

    bsr_pin_select #(.N_OUT(N_OUT), .N_TRI(N_TRI)) mux_i (
        .test_mode   (test_mode),
        .hold        (hold),
        .core_out    (core_out),
        .core_tri_d  (core_tri_d),
        .core_tri_oe (core_tri_oe),
        .pin_out     (pin_out),
        .pin_tri_d   (pin_tri_d),
        .pin_tri_oe  (pin_tri_oe)
    );

endmodule

// File: rtl/bsr_segment_chk.sv
// Checker for bsr_segment, bound to every instance. It watches the ports and
// the shift stages, and relates them over time.
module bsr_segment_chk #(
    parameter int N_OBS = 2,
    parameter int N_OUT = 3,
    parameter int N_TRI = 2,
    localparam int LEN = N_OBS + N_OUT + 2 * N_TRI,
    localparam int B   = N_OBS + N_OUT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_mode,
    input logic             capture_en,
    input logic             shift_en,
    input logic             update_en,
    input logic             tdi,
    input logic [N_OBS-1:0] pin_in,
    input logic [N_OUT-1:0] core_out,
    input logic [N_TRI-1:0] core_tri_d,
    input logic [N_TRI-1:0] core_tri_oe,
    input logic [N_OUT-1:0] pin_out,
    input logic [N_TRI-1:0] pin_tri_d,
    input logic [N_TRI-1:0] pin_tri_oe,
    input logic [LEN-1:0]   stage
);

    // R2: without test mode the core reaches the pads unchanged.
    a_r2_core_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (pin_out == core_out && pin_tri_d == core_tri_d
                        && pin_tri_oe == core_tri_oe));

    // R3: capture loads the observe cells from the pins and the outputs from the core.
    a_r3_capture_map: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> (stage[N_OBS-1:0] == $past(pin_in)
                        && stage[N_OBS +: N_OUT] == $past(core_out)));

    // R4: a shift moves every cell one place down and loads tdi at the top.
    a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=> (stage[LEN-2:0] == $past(stage[LEN-1:1])
                                       && stage[LEN-1] == $past(tdi)));

    // R5: in test mode the pins hold still unless an update happened.
    a_r5_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !update_en) |=> (!test_mode
            || $stable({pin_out, pin_tri_d, pin_tri_oe})));

    // R6: after an update in test mode the plain outputs show the updated stages.
    a_r6_update_out: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> (!test_mode || pin_out == $past(stage[N_OBS +: N_OUT])));

    // R11: without capture or shift the stages hold.
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_en && !shift_en) |=> $stable(stage));

    for (genvar k = 0; k < N_TRI; k++) begin : g_tri_chk
        // R7: the enable of each tri-state pin follows its own control cell.
        a_r7_ctl_gates_oe: assert property (@(posedge clk) disable iff (!rst_n)
            update_en |=> (!test_mode || pin_tri_oe[k] == $past(stage[B + 2*k + 1])));
        // R6: the data of each tri-state pin follows its data cell.
        a_r6_update_tri_d: assert property (@(posedge clk) disable iff (!rst_n)
            update_en |=> (!test_mode || pin_tri_d[k] == $past(stage[B + 2*k])));
    end

endmodule

bind bsr_segment bsr_segment_chk #(
    .N_OBS (N_OBS),
    .N_OUT (N_OUT),
    .N_TRI (N_TRI)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_mode   (test_mode),
    .capture_en  (capture_en),
    .shift_en    (shift_en),
    .update_en   (update_en),
    .tdi         (tdi),
    .pin_in      (pin_in),
    .core_out    (core_out),
    .core_tri_d  (core_tri_d),
    .core_tri_oe (core_tri_oe),
    .pin_out     (pin_out),
    .pin_tri_d   (pin_tri_d),
    .pin_tri_oe  (pin_tri_oe),
    .stage       (stage)
);

// File: tb/bsr_segment_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for bsr_segment. The driver tasks push the expected tdo
// stream into a queue, and a monitor pops and compares it at each falling
// edge while shifting. Pin checks are made directly at falling edges.
module bsr_segment_tb_top;

    localparam int N_OBS = 2;
    localparam int N_OUT = 3;
    localparam int N_TRI = 2;
    localparam int LEN   = N_OBS + N_OUT + 2 * N_TRI;
    localparam int B     = N_OBS + N_OUT;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             test_mode = 1'b0;
    logic             capture_en = 1'b0;
    logic             shift_en = 1'b0;
    logic             update_en = 1'b0;
    logic             tdi = 1'b0;
    logic             tdo;
    logic [N_OBS-1:0] pin_in = '0;
    logic [N_OUT-1:0] core_out = '0;
    logic [N_TRI-1:0] core_tri_d = '0;
    logic [N_TRI-1:0] core_tri_oe = '0;
    logic [N_OUT-1:0] pin_out;
    logic [N_TRI-1:0] pin_tri_d;
    logic [N_TRI-1:0] pin_tri_oe;

    bsr_segment #(.N_OBS(N_OBS), .N_OUT(N_OUT), .N_TRI(N_TRI)) dut_i (
        .clk (clk), .rst_n (rst_n), .test_mode (test_mode),
        .capture_en (capture_en), .shift_en (shift_en), .update_en (update_en),
        .tdi (tdi), .tdo (tdo), .pin_in (pin_in), .core_out (core_out),
        .core_tri_d (core_tri_d), .core_tri_oe (core_tri_oe),
        .pin_out (pin_out), .pin_tri_d (pin_tri_d), .pin_tri_oe (pin_tri_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;
    exp_t sb_q[$];
    logic sample_tdo = 1'b0;

    // Monitor: compare tdo with the next expected bit while shifting.
    always @(negedge clk) begin
        if (sample_tdo) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4 scoreboard empty, actual tdo=%0b expected=<item>", tdo);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (tdo !== e.v) begin
                    n_fail++;
                    $display("FAIL %s tdo actual=%0b expected=%0b", e.tag, tdo, e.v);
                end
            end
        end
    end

    // Capture vector expected from the layout given in R3.
    function automatic logic [LEN-1:0] cap_expect();
        logic [LEN-1:0] v;
        for (int i = 0; i < N_OBS; i++) v[i] = pin_in[i];
        for (int j = 0; j < N_OUT; j++) v[N_OBS + j] = core_out[j];
        for (int k = 0; k < N_TRI; k++) begin
            v[B + 2*k]     = core_tri_d[k];
            v[B + 2*k + 1] = core_tri_oe[k];
        end
        return v;
    endfunction

    task automatic check_val(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all pins with explicit expected values at the falling edge.
    task automatic check_pins(input logic [N_OUT-1:0] eo, input logic [N_TRI-1:0] ed,
                              input logic [N_TRI-1:0] eoe, input string tag);
        @(negedge clk);
        check_val(32'(pin_out), 32'(eo), {tag, " pin_out"});
        check_val(32'(pin_tri_d), 32'(ed), {tag, " pin_tri_d"});
        check_val(32'(pin_tri_oe), 32'(eoe), {tag, " pin_tri_oe"});
    endtask

    // Pins expected in test mode from a latched pattern (R6 layout).
    task automatic check_latched(input logic [LEN-1:0] pat, input string tag);
        logic [N_TRI-1:0] d;
        logic [N_TRI-1:0] oe;
        for (int k = 0; k < N_TRI; k++) begin
            d[k]  = pat[B + 2*k];
            oe[k] = pat[B + 2*k + 1];
        end
        check_pins(pat[N_OBS +: N_OUT], d, oe, tag);
    endtask

    task automatic check_core(input string tag);
        check_pins(core_out, core_tri_d, core_tri_oe, tag);
    endtask

    // Driver. mode 0: no capture. mode 1: capture. mode 2: capture together
    // with shift. Then idle cycles, then LEN shifts that load pattern ld and
    // expect the stream ex on tdo.
    task automatic scan_xfer(input logic [LEN-1:0] ld, input logic [LEN-1:0] ex,
                             input string tag, input int mode, input int idle);
        if (mode != 0) begin
            capture_en = 1'b1;
            shift_en   = (mode == 2);
            tdi        = 1'b1;
            @(posedge clk); #1;
            capture_en = 1'b0;
            shift_en   = 1'b0;
        end
        for (int c = 0; c < idle; c++) begin
            @(posedge clk); #1;
        end
        for (int t = 0; t < LEN; t++) begin
            exp_t e;
            e.v = ex[t];
            e.tag = tag;
            sb_q.push_back(e);
            shift_en   = 1'b1;
            tdi        = ld[t];
            sample_tdo = 1'b1;
            @(posedge clk); #1;
        end
        shift_en   = 1'b0;
        sample_tdo = 1'b0;
    endtask

    task automatic pulse_update();
        update_en = 1'b1;
        @(posedge clk); #1;
        update_en = 1'b0;
    endtask

    initial begin
        logic [LEN-1:0] cap;
        logic [LEN-1:0] ld_b;
        logic [LEN-1:0] ld_c;
        logic [LEN-1:0] ld_d;

        // R1: reset with test mode on and the core driving all ones.
        test_mode   = 1'b1;
        core_out    = '1;
        core_tri_d  = '1;
        core_tri_oe = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_pins('0, '0, '0, "R1 reset latches");
        check_val(32'(tdo), 32'd0, "R1 reset tdo");

        // R2: normal mode follows the core for two patterns.
        @(posedge clk); #1;
        test_mode = 1'b0;
        check_core("R2 core all ones");
        core_out = 3'b010; core_tri_d = 2'b01; core_tri_oe = 2'b10;
        check_core("R2 core mixed");

        // R3, R4: first capture pattern; the load pattern is arbitrary.
        pin_in = 2'b10; core_out = 3'b101; core_tri_d = 2'b01; core_tri_oe = 2'b10;
        cap = cap_expect();
        scan_xfer(9'b101101101, cap, "R3 capture A", 1, 0);
        check_core("R2 pins on core during scan");

        // R3: inverted pattern; R10: the load becomes a preload.
        pin_in = 2'b01; core_out = 3'b010; core_tri_d = 2'b10; core_tri_oe = 2'b01;
        cap = cap_expect();
        ld_b = 9'b110011010;
        scan_xfer(ld_b, cap, "R3 capture B", 1, 0);
        pulse_update();
        check_core("R10 preload keeps core");
        test_mode = 1'b1;
        check_latched(ld_b, "R10 preload shown at test entry");

        // R6: core changes are ignored in test mode.
        core_out = ~core_out; core_tri_d = ~core_tri_d; core_tri_oe = ~core_tri_oe;
        check_latched(ld_b, "R6 core ignored");

        // R4: read back exactly what was shifted in; R5: pins hold until update.
        ld_c = 9'b010110111;
        scan_xfer(ld_c, ld_b, "R4 shift path", 0, 0);
        check_latched(ld_b, "R5 pins hold before update");
        pulse_update();
        // R7: ld_c has both data cells at 1 and both control cells at 0.
        check_pins(3'b101, 2'b11, 2'b00, "R7 control 0 disables");

        // R8: only the observe bits differ; no pin changes after update.
        ld_d = ld_c ^ 9'b000000011;
        scan_xfer(ld_d, ld_c, "R4 shift path 2", 0, 0);
        pulse_update();
        check_latched(ld_c, "R8 observe bits reach no pin");

        // R9: capture and shift on the same edge keep the captured vector.
        pin_in = 2'b11; core_out = 3'b001; core_tri_d = 2'b10; core_tri_oe = 2'b11;
        cap = cap_expect();
        scan_xfer(9'b000000000, cap, "R9 capture wins", 2, 0);

        // R11: idle cycles after a capture keep the stages.
        pin_in = 2'b00; core_out = 3'b110; core_tri_d = 2'b11; core_tri_oe = 2'b01;
        cap = cap_expect();
        scan_xfer(9'b111111111, cap, "R11 idle hold", 1, 3);
        check_latched(ld_c, "R5 pins hold after capture");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired, actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule